// File: doc/BRIEF.md
# Trigger-Latched Six-Channel PWM Generator

This block drives six independent pulse-width outputs from a single clock. Each channel divides the clock by a 3-bit prescaler, then counts a 24-bit period. The output is active for the first part of every period, for as many prescaled ticks as the channel's high-time count. A polarity bit chooses whether active means high or low. There is no enable bit. A high-time count of zero parks the output at its inactive level, and software uses this to switch a channel off.

Software reaches the block through a small word-addressed register port with write and read strobes. All writes land in staging registers, and a running channel never sees them directly. A channel takes a snapshot of its staged settings when its trigger bit goes from 0 to 1. The smooth bit, sampled at that edge, decides when the snapshot becomes the running waveform. With smooth set, the change waits for the end of the period now in progress, so the output never carries a torn cycle. With smooth clear, the change lands after a short fixed delay and restarts the period. While a channel's trigger and smooth bits are both 0, its pin is forced high.

Top module: `pwm_trigbank`

## Requirements
- R1: After reset, every register reads 0 and every output is high.
- R2: Word address 0 is the control register: trigger in bit n, polarity in bit 8+n, output type in bit 16+n, smooth in bit 24+n, all for channel n. Word address 1 holds the prescale of channel n in bits 4n+2..4n. Word address 2+2n holds the 24-bit period count and 3+2n the 24-bit high-time count. Addresses 0 and 1 read back the last 32-bit value written. The count registers read back bits 23..0 of the last write, with bits 31..24 reading 0. An unmapped address ignores writes and reads 0. Read data appears in the cycle after the read strobe.
- R3: A running channel with prescale P, period count N and high-time count D repeats every (P+1)·max(N,2) clocks. Each period starts with (P+1)·min(D,max(N,2)) active clocks, followed by inactive clocks for the rest of the period.
- R4: With polarity 1 the active level is high. With polarity 0 the output is inverted, so active is low.
- R5: With D = 0 the output stays at its inactive level. With D ≥ max(N,2) the output stays at its active level.
- R6: Writes to the prescale, count and polarity fields have no effect on a running output until that channel's trigger bit rises.
- R7: If smooth is 0 when trigger rises, the new settings drive the output starting on the 4th rising clock edge after the write that set the trigger bit. The period restarts with its active part at that edge.
- R8: If smooth is 1 when trigger rises, the new settings take effect at the end of the period in progress, and the new period starts there.
- R9: While a channel's trigger and smooth bits are both 0, its output is held high. Otherwise the output follows the committed waveform.
- R10: Configuring or triggering one channel leaves the outputs of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the counters and registers |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe; data follows one cycle later |
| addr | input | 4 | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, held until the next read |
| pwm_out | output | 6 | One waveform output per channel |

## Verification
The assertions assume that software never raises a channel's trigger again before that channel's previous commit has taken place. If a new rising edge arrives in the same cycle as a pending commit, the new snapshot replaces the pending one. To stay clear of this case, the stimulus waits out the immediate-commit delay, or the period boundary, before it touches the trigger bit again. The bench keeps its own shadow copy of the control word, and every control write changes only the channel under test. Waveform windows are sampled for exactly one full period, so the high-cycle counts do not depend on the phase.

// File: rtl/pwm_trigbank_pkg.sv
package pwm_trigbank_pkg;

    localparam int DATA_W      = 32;
    localparam int CNT_W       = 24;
    localparam int PS_W        = 3;
    localparam int PS_STRIDE   = 4;
    localparam int POL_LANE    = 8;
    localparam int TYPE_LANE   = 16;
    localparam int SMOOTH_LANE = 24;

    localparam int ADDR_CTRL    = 0;
    localparam int ADDR_PRESC   = 1;
    localparam int ADDR_CH_BASE = 2;

    localparam int MIN_PERIOD = 2;

    typedef struct packed {
        logic [PS_W-1:0]  presc;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] duty;
        logic             pol;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        CM_IDLE,
        CM_IMM,
        CM_SMOOTH
    } commit_mode_e;

    function automatic logic [CNT_W-1:0] eff_period(input logic [CNT_W-1:0] p);
        return (p < CNT_W'(MIN_PERIOD)) ? CNT_W'(MIN_PERIOD) : p;
    endfunction

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_trigbank_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    output logic [NUM_CH-1:0]   trig_o,
    output logic [NUM_CH-1:0]   smooth_o,
    output logic [NUM_CH-1:0]   pol_o,
    output logic [PS_W-1:0]     presc_o  [NUM_CH],
    output logic [CNT_W-1:0]    period_o [NUM_CH],
    output logic [CNT_W-1:0]    duty_o   [NUM_CH]
);

    localparam int LAST_ADDR = ADDR_CH_BASE + 2 * NUM_CH - 1;

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] presc_q;
    logic [DATA_W-1:0] rd_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            presc_q <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(ADDR_CTRL))  ctrl_q  <= wr_data;
            if (addr == ADDR_W'(ADDR_PRESC)) presc_q <= wr_data;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                period_o[g] <= '0;
                duty_o[g]   <= '0;
            end else if (wr_en) begin
                if (addr == ADDR_W'(ADDR_CH_BASE + 2 * g))
                    period_o[g] <= wr_data[CNT_W-1:0];
                if (addr == ADDR_W'(ADDR_CH_BASE + 2 * g + 1))
                    duty_o[g] <= wr_data[CNT_W-1:0];
            end
        end
        assign trig_o[g]   = ctrl_q[g];
        assign pol_o[g]    = ctrl_q[POL_LANE + g];
        assign smooth_o[g] = ctrl_q[SMOOTH_LANE + g];
        assign presc_o[g]  = presc_q[PS_STRIDE * g +: PS_W];
    end

    always_comb begin
        rd_next = '0;
        if (addr == ADDR_W'(ADDR_CTRL))  rd_next = ctrl_q;
        if (addr == ADDR_W'(ADDR_PRESC)) rd_next = presc_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(ADDR_CH_BASE + 2 * i))
                rd_next = {{(DATA_W - CNT_W){1'b0}}, period_o[i]};
            if (addr == ADDR_W'(ADDR_CH_BASE + 2 * i + 1))
                rd_next = {{(DATA_W - CNT_W){1'b0}}, duty_o[i]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

    AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (rst) (rd_en && (32'(addr) > LAST_ADDR)) |=> (rd_data == '0)); // R2
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst) (!rd_en) |=> $stable(rd_data)); // R2

endmodule

// File: rtl/pwm_commit.sv
module pwm_commit
    import pwm_trigbank_pkg::*;
#(
    parameter int IMM_LAT = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      trig,
    input  logic      smooth,
    input  chan_cfg_t staged,
    input  logic      period_end,
    output chan_cfg_t active,
    output logic      load
);

    localparam int DLY_W = (IMM_LAT > 2) ? $clog2(IMM_LAT) : 1;

    logic         trig_q;
    logic         rise;
    chan_cfg_t    snap;
    commit_mode_e mode;
    logic [DLY_W-1:0] dly;

    assign rise = trig & ~trig_q;
    assign load = ((mode == CM_IMM) && (dly == DLY_W'(1))) ||
                  ((mode == CM_SMOOTH) && period_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b0;
            snap   <= '0;
            mode   <= CM_IDLE;
            dly    <= '0;
            active <= '0;
        end else begin
            trig_q <= trig;
            if (rise) begin
                snap <= staged;
                mode <= smooth ? CM_SMOOTH : CM_IMM;
                dly  <= DLY_W'(IMM_LAT - 1);
            end else if (load) begin
                mode <= CM_IDLE;
            end else if (mode == CM_IMM) begin
                dly <= dly - DLY_W'(1);
            end
            if (load) active <= snap;
        end
    end

    AST_SMOOTH_WAITS: assert property (@(posedge clk) disable iff (rst) (mode == CM_SMOOTH && !period_end && !rise) |=> (mode == CM_SMOOTH)); // R8
    AST_EDGE_ARMS: assert property (@(posedge clk) disable iff (rst) rise |=> (mode != CM_IDLE)); // R7

endmodule

// File: rtl/pwm_wavegen.sv
module pwm_wavegen
    import pwm_trigbank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t cfg,
    input  logic      load,
    input  logic      hold,
    output logic      out,
    output logic      period_end
);

    logic [PS_W-1:0]  pc;
    logic [CNT_W-1:0] tc;
    logic [CNT_W-1:0] per_eff;
    logic             presc_wrap;
    logic             level;

    assign per_eff    = eff_period(cfg.period);
    assign presc_wrap = (pc == cfg.presc);
    assign period_end = presc_wrap && (tc == per_eff - CNT_W'(1));
    assign level      = (tc < cfg.duty);
    assign out        = hold ? 1'b1 : (cfg.pol ? level : ~level);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            pc <= '0;
            tc <= '0;
        end else if (presc_wrap) begin
            pc <= '0;
            tc <= period_end ? '0 : tc + CNT_W'(1);
        end else begin
            pc <= pc + PS_W'(1);
        end
    end

    AST_ACTIVE_STABLE: assert property (@(posedge clk) disable iff (rst) (!load) |=> $stable(cfg)); // R6
    AST_TICK_RANGE: assert property (@(posedge clk) disable iff (rst) (tc < per_eff) && (pc <= cfg.presc)); // R3
    AST_PERIOD_START: assert property (@(posedge clk) disable iff (rst) (tc == '0 && cfg.duty != '0 && !hold) |-> (out == cfg.pol)); // R3
    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (rst) (cfg.duty == '0 && !hold) |-> (out == !cfg.pol)); // R5

endmodule

// File: rtl/pwm_trigbank.sv
module pwm_trigbank
    import pwm_trigbank_pkg::*;
#(
    parameter int NUM_CH  = 6,
    parameter int ADDR_W  = 4,
    parameter int IMM_LAT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] pwm_out
);

    // NUM_CH is at most 8: each control lane is 8 bits wide.
    logic [NUM_CH-1:0] trig_v;
    logic [NUM_CH-1:0] smooth_v;
    logic [NUM_CH-1:0] pol_v;
    logic [PS_W-1:0]   presc_a  [NUM_CH];
    logic [CNT_W-1:0]  period_a [NUM_CH];
    logic [CNT_W-1:0]  duty_a   [NUM_CH];

    pwm_regfile #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .trig_o   (trig_v),
        .smooth_o (smooth_v),
        .pol_o    (pol_v),
        .presc_o  (presc_a),
        .period_o (period_a),
        .duty_o   (duty_a)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        chan_cfg_t staged;
        chan_cfg_t active;
        logic      load;
        logic      period_end;
        logic      hold;

        always_comb begin
            staged.presc  = presc_a[g];
            staged.period = period_a[g];
            staged.duty   = duty_a[g];
            staged.pol    = pol_v[g];
        end

        assign hold = ~trig_v[g] & ~smooth_v[g];

        pwm_commit #(
            .IMM_LAT (IMM_LAT)
        ) u_commit (
            .clk        (clk),
            .rst        (rst),
            .trig       (trig_v[g]),
            .smooth     (smooth_v[g]),
            .staged     (staged),
            .period_end (period_end),
            .active     (active),
            .load       (load)
        );

        pwm_wavegen u_wave (
            .clk        (clk),
            .rst        (rst),
            .cfg        (active),
            .load       (load),
            .hold       (hold),
            .out        (pwm_out[g]),
            .period_end (period_end)
        );
    end

endmodule

// File: tb/pwm_trigbank_test.sv
module pwm_trigbank_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [2:0]  ps;
        logic [23:0] per;
        logic [23:0] dut;
        logic        pol;
        logic [15:0] total;
        logic [15:0] high;
        logic        first;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 24'd10, 24'd3, 1'b1, 16'd10, 16'd3,  1'b1},
        '{3'd1, 24'd5,  24'd2, 1'b1, 16'd10, 16'd4,  1'b1},
        '{3'd0, 24'd8,  24'd8, 1'b1, 16'd8,  16'd8,  1'b1},
        '{3'd0, 24'd6,  24'd0, 1'b1, 16'd6,  16'd0,  1'b0},
        '{3'd2, 24'd4,  24'd1, 1'b0, 16'd12, 16'd9,  1'b0},
        '{3'd0, 24'd1,  24'd1, 1'b1, 16'd2,  16'd1,  1'b1},
        '{3'd7, 24'd3,  24'd2, 1'b1, 16'd24, 16'd16, 1'b1},
        '{3'd0, 24'd5,  24'd9, 1'b0, 16'd5,  16'd0,  1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [5:0]  pwm_out;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [31:0] ctl = '0;
    logic [31:0] psr = '0;

    pwm_trigbank uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tg, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tg, got, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    // Stage settings with smooth=1/trigger=0, then raise trigger with smooth=0.
    task automatic cfg_imm(input int ch, input logic [2:0] ps, input logic [23:0] per,
                           input logic [23:0] dut, input logic pol);
        ctl[24 + ch] = 1'b1; ctl[ch] = 1'b0;
        reg_write(4'd0, ctl);
        psr[4 * ch +: 3] = ps;
        reg_write(4'd1, psr);
        reg_write(4'(2 + 2 * ch), {8'h0, per});
        reg_write(4'(3 + 2 * ch), {8'h0, dut});
        ctl[8 + ch] = pol; ctl[24 + ch] = 1'b0; ctl[ch] = 1'b1;
        reg_write(4'd0, ctl);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        int cnt, c0, c1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 outputs", 32'(pwm_out), 32'h3f);
        reg_read(4'd0, rv); check("R1 ctrl", rv, 0);
        reg_read(4'd3, rv); check("R1 duty0", rv, 0);

        // R3 R4 R5 table walk on channel 0
        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = (VECS[i].dut == 0 || VECS[i].dut >= VECS[i].per) ? "R5" :
                 (VECS[i].pol ? "R3" : "R4");
            cfg_imm(0, VECS[i].ps, VECS[i].per, VECS[i].dut, VECS[i].pol);
            repeat (4) @(negedge clk);
            check({tg, " first"}, 32'(pwm_out[0]), 32'(VECS[i].first));
            cnt = int'(pwm_out[0]);
            for (int k = 1; k < int'(VECS[i].total); k++) begin
                @(negedge clk);
                cnt += int'(pwm_out[0]);
            end
            check({tg, " high count"}, cnt, 32'(VECS[i].high));
            @(negedge clk);
            check("R3 repeat", 32'(pwm_out[0]), 32'(VECS[i].first));
            check("R10 others", 32'(pwm_out[5:1]), 32'h1f);
        end

        // R7 immediate latency: old waveform held low, new one held high
        cfg_imm(0, 3'd0, 24'd4, 24'd4, 1'b1);
        repeat (3) @(negedge clk);
        check("R7 before", 32'(pwm_out[0]), 0);
        @(negedge clk);
        check("R7 after", 32'(pwm_out[0]), 1);

        // R6 staged writes without a trigger edge
        reg_write(4'd3, 32'd0);
        reg_write(4'd2, 32'd9);
        psr[2:0] = 3'd5; reg_write(4'd1, psr);
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            cnt += int'(pwm_out[0]);
        end
        check("R6 untouched", cnt, 20);

        // R8 smooth commit at the period boundary
        cfg_imm(0, 3'd0, 24'd20, 24'd0, 1'b1);
        repeat (4) @(negedge clk);
        c0 = cyc;
        ctl[24] = 1'b1; ctl[0] = 1'b0; reg_write(4'd0, ctl);
        reg_write(4'd3, 32'd20);
        ctl[0] = 1'b1; reg_write(4'd0, ctl);
        check("R8 still old", 32'(pwm_out[0]), 0);
        c1 = 0;
        for (int k = 0; k < 60 && c1 == 0; k++) begin
            @(negedge clk);
            if (pwm_out[0]) c1 = cyc;
        end
        check("R8 boundary", c1 - c0, 20);

        // R9 hold-high when trigger and smooth are both low
        cfg_imm(0, 3'd0, 24'd4, 24'd0, 1'b1);
        repeat (6) @(negedge clk);
        check("R9 running low", 32'(pwm_out[0]), 0);
        ctl[0] = 1'b0; ctl[24] = 1'b0; reg_write(4'd0, ctl);
        check("R9 held high", 32'(pwm_out[0]), 1);
        ctl[24] = 1'b1; reg_write(4'd0, ctl);
        check("R9 waveform back", 32'(pwm_out[0]), 0);

        // R10 channel independence
        cfg_imm(3, 3'd0, 24'd4, 24'd0, 1'b1);
        repeat (5) @(negedge clk);
        check("R10 two channels", 32'(pwm_out), 32'h36);

        // R2 register map and readback
        ctl[16] = 1'b1; reg_write(4'd0, ctl);
        reg_read(4'd0, rv); check("R2 ctrl", rv, ctl);
        reg_read(4'd1, rv); check("R2 presc", rv, psr);
        reg_write(4'd12, 32'hffabcdef);
        reg_read(4'd12, rv); check("R2 period ch5", rv, 32'h00abcdef);
        reg_write(4'd14, 32'h12345678);
        reg_read(4'd14, rv); check("R2 unmapped", rv, 0);
        reg_read(4'd15, rv); check("R2 unmapped top", rv, 0);
        check("R10 after ch5 write", 32'(pwm_out), 32'h36);

        // R1 reset in mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 outputs again", 32'(pwm_out), 32'h3f);
        reg_read(4'd0, rv); check("R1 ctrl again", rv, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule